// File: doc/BRIEF.md
# Booth Recoded Integer Multiplier

This block multiplies two 8-bit integers and returns their full 16-bit product without any clock, register or handshake. The output settles as soon as either operand changes. It is meant to sit inside a larger datapath, for example a floating-point unit that needs a mantissa product, and it never uses the language's built-in multiply operator.

The product comes from radix-2 Booth recoding. A zero is placed below the multiplier's least significant bit. Each multiplier bit, taken together with the bit beneath it, picks one of three steps for that position: add the shifted multiplicand, subtract it, or skip. The structure is fully unrolled, with one fixed recoding cell, one partial-product cell and one adder stage per bit position. No loop depends on data values.

The parameter `SIGNED_OPS` picks the operand type. When it is 1 (the default), both operands are two's complement. When it is 0, each operand gets a leading zero and is treated as a 9-bit positive value, so operands with the top bit set are multiplied as unsigned numbers. This suits mantissas.

Top module: `booth_multiplier`

## Requirements
- R1: Operands `mul_a` and `mul_b` are 8 bits and `product` is 16 bits. The product follows any operand change combinationally, with no clock.
- R2: With `SIGNED_OPS`=1, `product` equals the two's-complement product of `mul_a` and `mul_b`. Every result fits in 16 bits, so it is exact.
- R3: Recoding places an implicit 0 below bit 0 of the multiplier `mul_b`. For each position i, the pair (bit i, bit i-1) selects the step: 01 adds the multiplicand shifted left by i, 10 subtracts it, and 00 or 11 adds nothing.
- R4: The multiplicand is sign-extended to 16 bits before shifting. A negative `mul_a` times a positive `mul_b` therefore gives the correct negative product.
- R5: In signed mode, -128 × -128 gives 16384 (0x4000), and 127 × -128 gives -16256 (0xC080).
- R6: If either operand is zero, `product` is zero.
- R7: With `SIGNED_OPS`=0, both operands are unsigned 0..255 and `product` is their unsigned product. For example, 255 × 255 gives 0xFE01.
- R8: In signed mode, when both operands are nonzero, `product` bit 15 equals the XOR of bit 7 of the two operands.
- R9: In signed mode, a multiplier of all ones (-1) makes `product` equal to the negated, sign-extended multiplicand.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mul_a | input | 8 | Multiplicand |
| mul_b | input | 8 | Multiplier, the operand that is Booth-recoded |
| product | output | 16 | Full-width product |

## Verification
The bench targets the extreme operands: -128 × -128, whose magnitude is the only one that reaches bit 14. A design without sign extension or with a wrong subtract step turns that result negative or zero. The bench also covers -1 × -1 and 127 × -128. A multiplier made only of ones produces a single subtract step, and an off-by-one in the implicit low bit shows up there at once. Alternating bit patterns such as 0x55 and 0xAA switch steps at every position, which exposes a swapped add/subtract choice. The unsigned instance is driven with operands whose top bit is set, where a missing leading zero would produce a negative signed product instead.

// File: rtl/booth_pkg.sv
package booth_pkg;

    typedef enum logic [1:0] {
        STEP_NONE = 2'b00,
        STEP_ADD  = 2'b01,
        STEP_SUB  = 2'b10
    } step_e;

    // pair = {bit i, bit i-1} of the multiplier
    function automatic step_e recode_pair(input logic [1:0] pair);
        step_e s;
        case (pair)
            2'b01:   s = STEP_ADD;
            2'b10:   s = STEP_SUB;
            default: s = STEP_NONE;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
    import booth_pkg::*;
#(
    parameter int OW = 8
) (
    input  logic [OW-1:0] mplier,
    output step_e         steps [OW]
);

    genvar i;
    generate
        for (i = 0; i < OW; i++) begin : g_cell
            if (i == 0) begin : g_low
                assign steps[i] = recode_pair({mplier[0], 1'b0});
            end else begin : g_mid
                assign steps[i] = recode_pair({mplier[i], mplier[i-1]});
            end
        end
    endgenerate

    always_comb begin
        int active;
        active = 0;
        for (int k = 0; k < OW; k++) begin
            if (steps[k] != STEP_NONE) active++;
        end
        AST_ZERO_MPLIER_IDLE: assert (mplier != '0 || active == 0); // R3
        AST_ONES_SINGLE_SUB: assert (mplier != '1 || (active == 1 && steps[0] == STEP_SUB)); // R3
    end

endmodule

// File: rtl/booth_pp_gen.sv
module booth_pp_gen
    import booth_pkg::*;
#(
    parameter int OW    = 8,
    parameter int PW    = 16,
    parameter int SHIFT = 0
) (
    input  logic [OW-1:0] mcand,
    input  step_e         step,
    output logic [PW-1:0] pp
);

    localparam int EXT = PW - OW;

    logic [PW-1:0] mcand_sx;
    logic [PW-1:0] shifted;

    assign mcand_sx = {{EXT{mcand[OW-1]}}, mcand};
    assign shifted  = mcand_sx << SHIFT;

    always_comb begin
        case (step)
            STEP_ADD: pp = shifted;
            STEP_SUB: pp = (~shifted) + PW'(1);
            default:  pp = '0;
        endcase
    end

    always_comb begin
        AST_SKIP_IS_ZERO: assert (step != STEP_NONE || pp == '0); // R3
        AST_ADD_SUB_CANCEL: assert (step != STEP_SUB || (pp + shifted) == '0); // R3
    end

endmodule

// File: rtl/booth_accumulator.sv
module booth_accumulator #(
    parameter int TERMS = 8,
    parameter int PW    = 16
) (
    input  logic [PW-1:0] pps [TERMS],
    output logic [PW-1:0] sum
);

    logic [PW-1:0] partial [TERMS+1];

    assign partial[0] = '0;

    genvar i;
    generate
        for (i = 0; i < TERMS; i++) begin : g_stage
            assign partial[i+1] = partial[i] + pps[i];
        end
    endgenerate

    assign sum = partial[TERMS];

endmodule

// File: rtl/booth_multiplier.sv
module booth_multiplier
    import booth_pkg::*;
#(
    parameter int WIDTH      = 8,
    parameter bit SIGNED_OPS = 1'b1
) (
    input  logic [WIDTH-1:0]   mul_a,
    input  logic [WIDTH-1:0]   mul_b,
    output logic [2*WIDTH-1:0] product
);

    localparam int PW = 2 * WIDTH;
    localparam int OW = SIGNED_OPS ? WIDTH : WIDTH + 1;

    logic [OW-1:0] mcand;
    logic [OW-1:0] mplier;
    step_e         steps [OW];
    logic [PW-1:0] pps   [OW];

    generate
        if (SIGNED_OPS) begin : g_signed
            assign mcand  = mul_a;
            assign mplier = mul_b;
        end else begin : g_unsigned
            assign mcand  = {1'b0, mul_a};
            assign mplier = {1'b0, mul_b};
        end
    endgenerate

    booth_recoder #(.OW(OW)) u_recoder (
        .mplier (mplier),
        .steps  (steps)
    );

    genvar i;
    generate
        for (i = 0; i < OW; i++) begin : g_pp
            booth_pp_gen #(.OW(OW), .PW(PW), .SHIFT(i)) u_pp (
                .mcand (mcand),
                .step  (steps[i]),
                .pp    (pps[i])
            );
        end
    endgenerate

    booth_accumulator #(.TERMS(OW), .PW(PW)) u_acc (
        .pps (pps),
        .sum (product)
    );

    always_comb begin
        AST_ZERO_OPERAND: assert ((mul_a != '0 && mul_b != '0) || product == '0); // R6
    end

    generate
        if (SIGNED_OPS) begin : g_signed_checks
            always_comb begin
                AST_SIGN_RULE: assert (mul_a == '0 || mul_b == '0 || product[PW-1] == (mul_a[WIDTH-1] ^ mul_b[WIDTH-1])); // R8
                AST_NEG_ONE_MPLIER: assert (mul_b != '1 || (product + {{WIDTH{mul_a[WIDTH-1]}}, mul_a}) == '0); // R9
            end
        end else begin : g_unsigned_checks
            always_comb begin
                AST_UNSIGNED_BY_ONE: assert (mul_b != WIDTH'(1) || product == {{WIDTH{1'b0}}, mul_a}); // R7
            end
        end
    endgenerate

endmodule

// File: tb/tb_booth_multiplier.sv
module tb_booth_multiplier;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic [7:0]  a, b;
    logic [15:0] p_s, p_u;
    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    booth_multiplier #(.WIDTH(8), .SIGNED_OPS(1'b1)) dut (
        .mul_a (a), .mul_b (b), .product (p_s)
    );

    booth_multiplier #(.WIDTH(8), .SIGNED_OPS(1'b0)) dut_u (
        .mul_a (a), .mul_b (b), .product (p_u)
    );

    // {a, b, expected signed product}
    localparam logic [31:0] VEC [0:10] = '{
        {8'h00, 8'h00, 16'h0000},
        {8'h03, 8'h05, 16'h000F},
        {8'hFF, 8'hFF, 16'h0001},
        {8'h80, 8'h80, 16'h4000},
        {8'h7F, 8'h80, 16'hC080},
        {8'hF9, 8'h09, 16'hFFC1},
        {8'h64, 8'hFD, 16'hFED4},
        {8'h55, 8'h55, 16'h1C39},
        {8'hAA, 8'h55, 16'hE372},
        {8'h7F, 8'h7F, 16'h3F01},
        {8'h80, 8'h01, 16'hFF80}
    };

    task automatic drive(input logic [7:0] va, input logic [7:0] vb);
        @(negedge clk);
        a = va;
        b = vb;
        #1;
    endtask

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s a=%h b=%h got=%h expected=%h", req, a, b, got, exp);
        end
    endtask

    function automatic logic [15:0] ref_signed(input logic [7:0] x, input logic [7:0] y);
        int r;
        r = int'($signed(x)) * int'($signed(y));
        return r[15:0];
    endfunction

    function automatic logic [15:0] ref_unsigned(input logic [7:0] x, input logic [7:0] y);
        int r;
        r = int'(x) * int'(y);
        return r[15:0];
    endfunction

    initial begin
        #400000;
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired got=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        a = 8'h00;
        b = 8'h00;
        repeat (2) @(posedge clk);

        // initial state: zero operands give zero (R6)
        #1;
        check("R6 start", p_s, 16'h0000);
        check("R6 start unsigned", p_u, 16'h0000);

        // vector table (R2 R3 R5)
        for (int k = 0; k <= 10; k++) begin
            drive(VEC[k][31:24], VEC[k][23:16]);
            check("R2 table", p_s, VEC[k][15:0]);
        end

        // R1: output follows input change without a clock edge
        @(negedge clk);
        a = 8'h06; b = 8'h07;
        #0.5;
        check("R1 no-clock", p_s, 16'h002A);
        b = 8'h08;
        #0.5;
        check("R1 follow", p_s, 16'h0030);

        // R5 corners
        drive(8'h80, 8'h80);
        check("R5 min*min", p_s, 16'h4000);
        drive(8'h7F, 8'h80);
        check("R5 max*min", p_s, 16'hC080);

        // R4: negative multiplicand, positive multiplier
        drive(8'hF0, 8'h05);
        check("R4 sext", p_s, 16'hFFB0);

        // R6: zero on either side
        drive(8'h00, 8'h80);
        check("R6 a zero", p_s, 16'h0000);
        drive(8'hAB, 8'h00);
        check("R6 b zero", p_s, 16'h0000);
        check("R6 b zero unsigned", p_u, 16'h0000);

        // R9: multiplier of -1
        drive(8'h37, 8'hFF);
        check("R9 neg", p_s, 16'hFFC9);
        drive(8'h80, 8'hFF);
        check("R9 neg min", p_s, 16'h0080);

        // R3: single add step at bit 7 boundary, alternating steps
        drive(8'h01, 8'h40);
        check("R3 single", p_s, 16'h0040);
        drive(8'h01, 8'hAA);
        check("R3 alternating", p_s, 16'hFFAA);

        // R7: unsigned variant
        drive(8'hFF, 8'hFF);
        check("R7 255*255", p_u, 16'hFE01);
        drive(8'h80, 8'h80);
        check("R7 128*128", p_u, 16'h4000);
        drive(8'hC8, 8'h03);
        check("R7 200*3", p_u, 16'h0258);

        // R8 and R2 / R7 sweep over a strided grid
        for (int x = 0; x < 256; x += 7) begin
            for (int y = 0; y < 256; y += 5) begin
                drive(8'(x), 8'(y));
                check("R2 sweep", p_s, ref_signed(8'(x), 8'(y)));
                check("R7 sweep", p_u, ref_unsigned(8'(x), 8'(y)));
                if (x != 0 && y != 0) begin
                    check("R8 sign", {15'b0, p_s[15]}, {15'b0, a[7] ^ b[7]});
                end
            end
        end

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule